// File: doc/BRIEF.md
# User-Level Interrupt Channel Controller

This block sits beside a processor core's exception logic and lets user code watch memory for coherence activity without polling. It holds a small set of channels. Each channel holds an address window, given as a base and a compare mask, and the start address of the user routine that should run when a store lands in that window. Stores observed on the snoop port are compared against every armed channel. A hit leaves a sticky "fired" mark on that channel. When delivery is allowed, the block makes a yield request to the core. It asks the core to flush the pipeline and save the interrupted instruction pointer, and it steers fetch to the winning channel's routine.

The yield request ranks below every other interrupt or fault. Only one interrupt may be in service at a time: a blocking bit is set on delivery and cleared by a return command. A channel whose recorded code-segment value no longer matches the core's current one is held back. Events that arrive while delivery is not allowed remain marked and are delivered later. Software can read each channel's armed and fired state through a poll port at any time.

Top module: `uli_chan_ctrl`

## Requirements
- R1: After reset every channel is disarmed with no fired mark, the blocking bit is clear, the error flag is clear, and all strobes (redirect_vld, save_ip, flush, restore_ip) are 0.
- R2: A cycle with cfg_we high loads the selected channel with base, mask, handler and the current code segment, and sets its armed state to cfg_arm. From the next cycle the poll port shows that armed value for the channel, with fired 0.
- R3: A snoop store fires an armed channel when (addr & mask) == (base & mask); mask bits set to 1 are compared. The fired mark shows on the poll port one cycle after the snoop. A miss, or a disarmed channel, leaves the mark at 0.
- R4: One cycle after an eligible channel is seen while delivery is allowed, redirect_vld, save_ip and flush pulse high for exactly one cycle together, redirect_pc holds that channel's handler, blocked reads 1 and the channel's fired mark reads 0.
- R5: While blocked is 1, no redirect occurs, and new hits stay marked as fired.
- R6: A return command while blocked pulses restore_ip one cycle later and clears blocked. An event still marked is then delivered one cycle after that.
- R7: While irq_other is high, no redirect is issued; the fired mark is kept.
- R8: When several channels are eligible at once, the lowest index is delivered first.
- R9: A fired channel whose recorded code segment differs from cs_cur is not delivered. It is delivered once cs_cur matches again.
- R10: A return command while blocked is 0 produces no restore_ip pulse and sets the sticky ret_err flag.
- R11: A configuration write to a channel clears its fired mark, even if a hit is pending there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write the selected channel |
| cfg_sel | input | IDXW | Channel index for the write |
| cfg_arm | input | 1 | Armed state written to the channel |
| cfg_base | input | AW | Window base address |
| cfg_mask | input | AW | Window compare mask |
| cfg_handler | input | AW | User routine start address |
| cs_cur | input | CSW | Current code-segment value |
| snoop_vld | input | 1 | A store is observed |
| snoop_addr | input | AW | Address of the observed store |
| irq_other | input | 1 | A higher-priority interrupt or fault is pending |
| ret_cmd | input | 1 | Return from the user routine |
| poll_sel | input | IDXW | Channel index to poll |
| poll_armed | output | 1 | Polled channel is armed |
| poll_fired | output | 1 | Polled channel has fired |
| redirect_vld | output | 1 | Take the yield: redirect fetch |
| redirect_pc | output | AW | Fetch target for the redirect |
| save_ip | output | 1 | Push the interrupted instruction pointer |
| flush | output | 1 | Flush the pipeline |
| restore_ip | output | 1 | Pop the saved pointer and resume |
| blocked | output | 1 | A yield is in service |
| ret_err | output | 1 | Sticky: return seen while not in service |

## Verification
The bench builds the block with four channels, 32-bit addresses and an 8-bit code segment, so every channel index is used. Three channels can share one window, which drives the full priority chain through successive deliveries. A table of snoop addresses probes both edges of a 256-byte window and addresses outside it. Directed sequences cover held-off delivery from a pending higher interrupt, from the blocking bit and from a code-segment mismatch, each followed by its later release.

// File: rtl/uli_pkg.sv
package uli_pkg;
  localparam int MAXW = 64;

  // address falls inside a window: compared bits are those set in mask
  function automatic logic win_hit(input logic [MAXW-1:0] addr,
                                   input logic [MAXW-1:0] base,
                                   input logic [MAXW-1:0] mask);
    return ((addr ^ base) & mask) == '0;
  endfunction

  // lowest set bit as a one-hot vector
  function automatic logic [MAXW-1:0] low_first(input logic [MAXW-1:0] req);
    return req & (~req + 1'b1);
  endfunction
endpackage

// File: rtl/uli_chan.sv
module uli_chan #(
  parameter int AW  = 32,
  parameter int CSW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_arm,
  input  logic [AW-1:0]  wr_base,
  input  logic [AW-1:0]  wr_mask,
  input  logic [AW-1:0]  wr_handler,
  input  logic [CSW-1:0] wr_cs,
  input  logic           snoop_vld,
  input  logic [AW-1:0]  snoop_addr,
  input  logic           taken,
  output logic           armed,
  output logic           fired,
  output logic           hit,
  output logic [AW-1:0]  handler,
  output logic [CSW-1:0] cs_rec
);
  import uli_pkg::*;

  logic [AW-1:0] base_q, mask_q;

  always_comb
    hit = snoop_vld & armed &
          win_hit(MAXW'(snoop_addr), MAXW'(base_q), MAXW'(mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
      handler <= '0;
      cs_rec  <= '0;
    end else if (wr_en) begin
      armed   <= wr_arm;
      base_q  <= wr_base;
      mask_q  <= wr_mask;
      handler <= wr_handler;
      cs_rec  <= wr_cs;
    end
  end

  // reprogramming wipes the mark; a fresh hit outranks the clear on delivery
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fired <= 1'b0;
    else if (wr_en)  fired <= 1'b0;
    else if (hit)    fired <= 1'b1;
    else if (taken)  fired <= 1'b0;
  end
endmodule

// File: rtl/uli_pick.sv
module uli_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  import uli_pkg::*;

  logic [MAXW-1:0] one;

  always_comb begin
    one = low_first(MAXW'(req));
    gnt = one[N-1:0];
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/uli_deliver.sv
module uli_deliver #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_any,
  input  logic [AW-1:0] req_handler,
  input  logic          irq_other,
  input  logic          ret_cmd,
  output logic          take,
  output logic          ret_ok,
  output logic          ret_bad,
  output logic          redirect_vld,
  output logic [AW-1:0] redirect_pc,
  output logic          save_ip,
  output logic          flush,
  output logic          restore_ip,
  output logic          blocked,
  output logic          ret_err
);
  always_comb begin
    take    = req_any & ~blocked & ~irq_other;
    ret_ok  = ret_cmd & blocked;
    ret_bad = ret_cmd & ~blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      save_ip      <= 1'b0;
      flush        <= 1'b0;
      restore_ip   <= 1'b0;
      blocked      <= 1'b0;
      ret_err      <= 1'b0;
    end else begin
      redirect_vld <= take;
      save_ip      <= take;
      flush        <= take;
      restore_ip   <= ret_ok;
      if (take)         redirect_pc <= req_handler;
      if (take)         blocked <= 1'b1;
      else if (ret_ok)  blocked <= 1'b0;
      if (ret_bad)      ret_err <= 1'b1;
    end
  end
endmodule

// File: rtl/uli_chan_ctrl.sv
module uli_chan_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CSW = 8,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_sel,
  input  logic            cfg_arm,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_mask,
  input  logic [AW-1:0]   cfg_handler,
  input  logic [CSW-1:0]  cs_cur,
  input  logic            snoop_vld,
  input  logic [AW-1:0]   snoop_addr,
  input  logic            irq_other,
  input  logic            ret_cmd,
  input  logic [IDXW-1:0] poll_sel,
  output logic            poll_armed,
  output logic            poll_fired,
  output logic            redirect_vld,
  output logic [AW-1:0]   redirect_pc,
  output logic            save_ip,
  output logic            flush,
  output logic            restore_ip,
  output logic            blocked,
  output logic            ret_err
);
  logic [NCH-1:0]  armed_v, fired_v, hit_v, elig_v, gnt_v, clr_v;
  logic [AW-1:0]   hnd   [NCH];
  logic [CSW-1:0]  csr   [NCH];
  logic            elig_any, take, ret_ok, ret_bad;
  logic [IDXW-1:0] win_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_g;
    assign wr_g     = cfg_we && (cfg_sel == IDXW'(g));
    assign clr_v[g] = take & gnt_v[g];
    uli_chan #(.AW(AW), .CSW(CSW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_g),
      .wr_arm    (cfg_arm),
      .wr_base   (cfg_base),
      .wr_mask   (cfg_mask),
      .wr_handler(cfg_handler),
      .wr_cs     (cs_cur),
      .snoop_vld (snoop_vld),
      .snoop_addr(snoop_addr),
      .taken     (clr_v[g]),
      .armed     (armed_v[g]),
      .fired     (fired_v[g]),
      .hit       (hit_v[g]),
      .handler   (hnd[g]),
      .cs_rec    (csr[g])
    );
    assign elig_v[g] = armed_v[g] & fired_v[g] & (csr[g] == cs_cur);
  end

  uli_pick #(.N(NCH)) u_pick (
    .req(elig_v),
    .gnt(gnt_v),
    .any(elig_any),
    .idx(win_idx)
  );

  uli_deliver #(.AW(AW)) u_dlv (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_any     (elig_any),
    .req_handler (hnd[win_idx]),
    .irq_other   (irq_other),
    .ret_cmd     (ret_cmd),
    .take        (take),
    .ret_ok      (ret_ok),
    .ret_bad     (ret_bad),
    .redirect_vld(redirect_vld),
    .redirect_pc (redirect_pc),
    .save_ip     (save_ip),
    .flush       (flush),
    .restore_ip  (restore_ip),
    .blocked     (blocked),
    .ret_err     (ret_err)
  );

  assign poll_armed = armed_v[poll_sel];
  assign poll_fired = fired_v[poll_sel];
endmodule

// File: rtl/uli_chk.sv
module uli_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] gnt_v,
  input logic           irq_other,
  input logic           ret_cmd,
  input logic           redirect_vld,
  input logic           save_ip,
  input logic           flush,
  input logic           restore_ip,
  input logic           blocked,
  input logic           ret_err
);
  p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_v));

  p_strobes_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (save_ip && flush && blocked));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |=> !redirect_vld);

  p_no_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !redirect_vld);

  p_lowest_rank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_other |=> !redirect_vld);

  p_restore_unblocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cmd && blocked) |=> (restore_ip && !blocked));

  p_bad_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_cmd && !blocked) |=> (ret_err && !restore_ip));
endmodule

bind uli_chan_ctrl uli_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gnt_v       (gnt_v),
  .irq_other   (irq_other),
  .ret_cmd     (ret_cmd),
  .redirect_vld(redirect_vld),
  .save_ip     (save_ip),
  .flush       (flush),
  .restore_ip  (restore_ip),
  .blocked     (blocked),
  .ret_err     (ret_err)
);

// File: tb/sim_uli_chan_ctrl.sv
module sim_uli_chan_ctrl;
  localparam int NCH = 4, AW = 32, CSW = 8, IDXW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_arm = 0, snoop_vld = 0, irq_other = 0, ret_cmd = 0;
  logic [IDXW-1:0] cfg_sel = '0, poll_sel = '0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0, cfg_handler = '0, snoop_addr = '0;
  logic [CSW-1:0] cs_cur = '0;
  logic poll_armed, poll_fired, redirect_vld, save_ip, flush, restore_ip, blocked, ret_err;
  logic [AW-1:0] redirect_pc;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  uli_chan_ctrl #(.NCH(NCH), .AW(AW), .CSW(CSW)) u0 (.*);

  // window: base 0x1000, mask 0xFFFFFF00; entry = {expect_fired, addr}
  localparam logic [32:0] VEC [0:5] = '{
    {1'b1, 32'h0000_1000}, {1'b1, 32'h0000_10FF}, {1'b0, 32'h0000_1100},
    {1'b0, 32'h0000_0FFF}, {1'b1, 32'h0000_1080}, {1'b0, 32'h8000_1000}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic prog(input int ch, input logic arm, input logic [31:0] b,
                      input logic [31:0] m, input logic [31:0] h);
    cfg_we = 1; cfg_sel = IDXW'(ch); cfg_arm = arm;
    cfg_base = b; cfg_mask = m; cfg_handler = h;
    step();
    cfg_we = 0;
  endtask

  task automatic snoop(input logic [31:0] a);
    snoop_vld = 1; snoop_addr = a; step(); snoop_vld = 0;
  endtask

  task automatic poll(input int ch, input string req, input logic ea, input logic ef);
    poll_sel = IDXW'(ch); #1;
    chk({req, " armed"}, 32'(poll_armed), 32'(ea));
    chk({req, " fired"}, 32'(poll_fired), 32'(ef));
  endtask

  task automatic ret_pulse();
    ret_cmd = 1; step(); ret_cmd = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step();
    // R1 reset state
    chk("R1 strobes", {28'd0, redirect_vld, save_ip, flush, restore_ip}, 32'd0);
    chk("R1 blocked/err", {30'd0, blocked, ret_err}, 32'd0);
    for (int c = 0; c < NCH; c++) poll(c, "R1", 1'b0, 1'b0);

    // R2 program channel 0
    cs_cur = 8'd5; irq_other = 1;
    prog(0, 1'b1, 32'h1000, 32'hFFFF_FF00, 32'h4000);
    poll(0, "R2", 1'b1, 1'b0);
    poll(1, "R2 other", 1'b0, 1'b0);

    // R3 table walk, delivery held off by irq_other (R7)
    for (int i = 0; i < 6; i++) begin
      prog(0, 1'b1, 32'h1000, 32'hFFFF_FF00, 32'h4000);
      snoop(VEC[i][31:0]);
      poll(0, "R3 window", 1'b1, VEC[i][32]);
      poll(1, "R3 disarmed", 1'b0, 1'b0);
      chk("R7 held", 32'(redirect_vld), 32'd0);
    end

    // R11 write clears a pending mark
    snoop(32'h1010);
    poll(0, "R11 before", 1'b1, 1'b1);
    prog(0, 1'b1, 32'h1000, 32'hFFFF_FF00, 32'h4000);
    poll(0, "R11 after", 1'b1, 1'b0);

    // R7 then R4 delivery
    snoop(32'h1020);
    step(2);
    chk("R7 no redirect", 32'(redirect_vld), 32'd0);
    poll(0, "R7 kept", 1'b1, 1'b1);
    irq_other = 0;
    step();
    chk("R4 strobes", {29'd0, redirect_vld, save_ip, flush}, 32'd7);
    chk("R4 pc", redirect_pc, 32'h4000);
    chk("R4 blocked", 32'(blocked), 32'd1);
    poll(0, "R4 cleared", 1'b1, 1'b0);
    step();
    chk("R4 one pulse", 32'(redirect_vld), 32'd0);

    // R5 blocked: new hit stays pending
    snoop(32'h1030);
    step(2);
    chk("R5 no nest", 32'(redirect_vld), 32'd0);
    poll(0, "R5 pending", 1'b1, 1'b1);

    // R6 return then pending delivery
    ret_pulse();
    chk("R6 restore", 32'(restore_ip), 32'd1);
    chk("R6 unblocked", 32'(blocked), 32'd0);
    chk("R6 not yet", 32'(redirect_vld), 32'd0);
    step();
    chk("R6 redeliver", 32'(redirect_vld), 32'd1);
    chk("R6 pc", redirect_pc, 32'h4000);
    ret_pulse();

    // R10 return while not in service
    ret_pulse();
    chk("R10 no restore", 32'(restore_ip), 32'd0);
    chk("R10 err", 32'(ret_err), 32'd1);

    // R8 priority among three channels
    irq_other = 1;
    prog(1, 1'b1, 32'h1000, 32'hFFFF_FF00, 32'h5000);
    prog(2, 1'b1, 32'h1000, 32'hFFFF_FF00, 32'h6000);
    snoop(32'h1044);
    irq_other = 0;
    step();
    chk("R8 first", redirect_pc, 32'h4000);
    ret_pulse(); step();
    chk("R8 second", redirect_pc, 32'h5000);
    ret_pulse(); step();
    chk("R8 third", redirect_pc, 32'h6000);
    chk("R8 third vld", 32'(redirect_vld), 32'd1);
    ret_pulse(); step();
    chk("R8 drained", 32'(redirect_vld), 32'd0);

    // R9 code-segment mismatch
    cs_cur = 8'd7;
    prog(3, 1'b1, 32'h2000, 32'hFFFF_F000, 32'h7000);
    cs_cur = 8'd5;
    snoop(32'h2345);
    step(3);
    chk("R9 suppressed", 32'(redirect_vld), 32'd0);
    poll(3, "R9 pending", 1'b1, 1'b1);
    cs_cur = 8'd7;
    step();
    chk("R9 resumed", 32'(redirect_vld), 32'd1);
    chk("R9 pc", redirect_pc, 32'h7000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule